// File: doc/BRIEF.md
# Page Write Buffer with Array Protection

This block sits between a serial memory's bus front end and its 256 x 8 storage array. The front end decodes bus conditions and bytes and hands them over as single-cycle strobes: a start condition, the word address byte, each data byte, and the stop condition. The block gathers the data bytes of one write transaction into a 16-entry page buffer. The entry for each byte is chosen by the low four address bits, which advance and wrap inside the page. A transaction that carries more than sixteen bytes therefore overwrites its earliest bytes, so only the newest sixteen remain.

An accepted stop that follows at least one data byte starts a self-timed write cycle. The cycle lasts a programmable number of clock cycles, and busy stays high for all of it so that the front end can withhold acknowledges. In the first cycles of that window the buffered bytes are driven onto the array write port one per clock, in ascending slot order. Two protection rules filter these writes. A hardware protect input blocks every address. A software protect latch, set by a command strobe and cleared only by reset, blocks the lower half of the array. Blocked bytes are dropped, but the cycle still runs to its full length.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, busy and the array write enable are both low.
- R2: Data byte k of a transaction whose address byte is A is written to address {A[7:4], (A[3:0]+k) mod 16}. After the stop, the writes appear on the array port one per clock in ascending order of the low four address bits, and each slot that received a byte is written exactly once.
- R3: When more than 16 data bytes arrive, each later byte replaces the byte held in its slot, so only the newest 16 are committed.
- R4: A stop that comes with no data byte since the address byte, or a stop after a start strobe has discarded the transaction, starts no write cycle: busy stays low and nothing is written.
- R5: busy rises in the cycle after an accepted stop and stays high for exactly max(WC_CYCLES, 17) cycles. Every array write falls inside that window.
- R6: While busy is high, start, address, data and stop strobes are ignored. A stop given after busy falls, with no new address byte, starts nothing.
- R7: If the hardware protect input is high when the stop is accepted, no byte of that transaction is written, and busy still lasts the full length.
- R8: Once the software protect command has been given, bytes whose address has bit 7 equal to 0 (00h to 7Fh) are dropped. Bytes at 80h to FFh are still written.
- R9: No input except reset clears the software protect latch. Repeated commands and later transactions leave it set.
- R10: The protection that applies to a transaction is the state at the moment the stop is accepted. Changes to the hardware protect input during the write cycle have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start condition strobe; discards any open transaction |
| addr_vld | input | 1 | Word address byte strobe; opens a write transaction |
| addr_byte | input | ADDR_W | Word address byte |
| data_vld | input | 1 | Data byte strobe |
| data_byte | input | DATA_W | Data byte |
| bus_stop | input | 1 | Stop condition strobe |
| wp_pin | input | 1 | Hardware protect; high blocks the whole array |
| swp_cmd | input | 1 | Software protect command strobe; protects the lower half for good |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
The bench aims at the points where a page write is easy to get wrong. The first is a start address near the top of a page: a design that carries into the upper address bits would write into the next page. The second is a transaction of more than sixteen bytes: a design that stops accepting bytes, or drops the newest ones, would commit stale data in the low slots. Protection is tested in both halves, including a hardware protect that rises in the middle of a cycle. A design that checks protection per byte against the live input, or that cuts busy short for blocked writes, breaks the write stream or the busy length the scoreboard expects. The bench also sends stops with no data, stops after a discarding start, and strobes during busy. Any of these that leaks through shows up as a write nobody queued or as a busy pulse that should not be there.

// File: rtl/pgwr_pkg.sv
`timescale 1ns/1ps
package pgwr_pkg;

  typedef enum logic {
    TXN_IDLE = 1'b0,
    TXN_OPEN = 1'b1
  } txn_st_e;

  // a byte may be committed unless the pin blocks everything, or the
  // software latch is set and the byte targets the lower half
  function automatic logic wr_allowed(input logic addr_msb,
                                      input logic wp_lvl,
                                      input logic swp_lvl);
    return !wp_lvl && !(swp_lvl && !addr_msb);
  endfunction

endpackage

// File: rtl/pgwr_collect.sv
`timescale 1ns/1ps
module pgwr_collect #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     busy_i,
  input  logic                     start_i,
  input  logic                     addr_vld_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     byte_vld_i,
  input  logic [DATA_W-1:0]        byte_i,
  input  logic                     stop_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_vld_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o,
  output logic                     launch_o
);
  import pgwr_pkg::*;

  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;

  txn_st_e             st_q;
  logic [PAGE_W-1:0]   ptr_q;
  logic [HI_W-1:0]     page_q;
  logic [PAGE_N-1:0]   vld_q;
  logic [DATA_W-1:0]   mem_q [PAGE_N];
  logic                wr_en;
  logic                idle_ok;

  assign idle_ok = !busy_i;
  assign wr_en   = idle_ok && byte_vld_i && !start_i && !addr_vld_i && (st_q == TXN_OPEN);

  // page storage: single write port, no reset, so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[ptr_q] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= TXN_IDLE;
      ptr_q  <= '0;
      page_q <= '0;
      vld_q  <= '0;
    end else if (idle_ok) begin
      if (start_i) begin
        st_q  <= TXN_IDLE;
        vld_q <= '0;
      end else if (addr_vld_i) begin
        st_q   <= TXN_OPEN;
        page_q <= addr_i[ADDR_W-1:PAGE_W];
        ptr_q  <= addr_i[PAGE_W-1:0];
        vld_q  <= '0;
      end else if (wr_en) begin
        vld_q[ptr_q] <= 1'b1;
        ptr_q        <= ptr_q + 1'b1;
      end else if (stop_i) begin
        st_q <= TXN_IDLE;
      end
    end
  end

  assign launch_o  = idle_ok && stop_i && !start_i && !addr_vld_i && !byte_vld_i &&
                     (st_q == TXN_OPEN) && (|vld_q);
  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = vld_q[rd_idx_i];
  assign page_o    = page_q;

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> ($stable(vld_q) && $stable(ptr_q) && $stable(page_q))); // R6

  AST_START_DROPS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_i) |=> (vld_q == '0)); // R4

endmodule

// File: rtl/pgwr_guard.sv
`timescale 1ns/1ps
module pgwr_guard (
  input  logic clk,
  input  logic rst,
  input  logic swp_cmd_i,
  input  logic wp_i,
  input  logic launch_i,
  input  logic addr_msb_i,
  output logic allow_o
);
  import pgwr_pkg::*;

  logic swp_q;
  logic wp_snap_q;
  logic swp_snap_q;

  // one-way latch: only reset returns it to zero
  always_ff @(posedge clk) begin
    if (rst)            swp_q <= 1'b0;
    else if (swp_cmd_i) swp_q <= 1'b1;
  end

  // protection is frozen when the cycle is launched
  always_ff @(posedge clk) begin
    if (rst) begin
      wp_snap_q  <= 1'b0;
      swp_snap_q <= 1'b0;
    end else if (launch_i) begin
      wp_snap_q  <= wp_i;
      swp_snap_q <= swp_q;
    end
  end

  assign allow_o = wr_allowed(addr_msb_i, wp_snap_q, swp_snap_q);

  AST_SWP_STICKY: assert property (@(posedge clk) disable iff (rst)
    $past(swp_q) |-> swp_q); // R9

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !launch_i |=> ($stable(wp_snap_q) && $stable(swp_snap_q))); // R10

endmodule

// File: rtl/pgwr_timer.sv
`timescale 1ns/1ps
module pgwr_timer #(
  parameter int WC_CYCLES = 500000,
  parameter int PAGE_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch_i,
  output logic              busy_o,
  output logic              scan_o,
  output logic [PAGE_W-1:0] idx_o
);
  localparam int PAGE_N   = 1 << PAGE_W;
  localparam int MIN_LEN  = PAGE_N + 1;
  localparam int BUSY_LEN = (WC_CYCLES > MIN_LEN) ? WC_CYCLES : MIN_LEN;
  localparam int CNT_W    = $clog2(BUSY_LEN + 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              scan_q;
  logic [PAGE_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      scan_q <= 1'b0;
      idx_q  <= '0;
    end else if (launch_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_LEN - 1);
      scan_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (scan_q) begin
        if (idx_q == PAGE_W'(PAGE_N - 1)) scan_q <= 1'b0;
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign scan_o = scan_q;
  assign idx_o  = idx_q;

  // checker: length of every busy window
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)         run_q <= '0;
    else if (busy_q) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> (run_q == CNT_W'(BUSY_LEN))); // R5

  AST_SCAN_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    scan_q |-> busy_q); // R5

endmodule

// File: rtl/pgwr_commit.sv
`timescale 1ns/1ps
module pgwr_commit #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int WC_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_byte,
  input  logic              data_vld,
  input  logic [DATA_W-1:0] data_byte,
  input  logic              bus_stop,
  input  logic              wp_pin,
  input  logic              swp_cmd,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              busy_w;
  logic              scan_w;
  logic [PAGE_W-1:0] idx_w;
  logic [DATA_W-1:0] rd_data_w;
  logic              rd_vld_w;
  logic [HI_W-1:0]   page_w;
  logic              launch_w;
  logic              allow_w;

  pgwr_collect #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_collect (
    .clk       (clk),
    .rst       (rst),
    .busy_i    (busy_w),
    .start_i   (bus_start),
    .addr_vld_i(addr_vld),
    .addr_i    (addr_byte),
    .byte_vld_i(data_vld),
    .byte_i    (data_byte),
    .stop_i    (bus_stop),
    .rd_idx_i  (idx_w),
    .rd_data_o (rd_data_w),
    .rd_vld_o  (rd_vld_w),
    .page_o    (page_w),
    .launch_o  (launch_w)
  );

  pgwr_guard u_guard (
    .clk       (clk),
    .rst       (rst),
    .swp_cmd_i (swp_cmd),
    .wp_i      (wp_pin),
    .launch_i  (launch_w),
    .addr_msb_i(page_w[HI_W-1]),
    .allow_o   (allow_w)
  );

  pgwr_timer #(.WC_CYCLES(WC_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .launch_i(launch_w),
    .busy_o  (busy_w),
    .scan_o  (scan_w),
    .idx_o   (idx_w)
  );

  // registered array port
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we    <= scan_w && rd_vld_w && allow_w;
      arr_addr  <= {page_w, idx_w};
      arr_wdata <= rd_data_w;
    end
  end

  assign busy = busy_w;

  // checker: independent record of protection seen at launch
  logic chk_swp_q, chk_wp_q, chk_swp_at_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_swp_q    <= 1'b0;
      chk_wp_q     <= 1'b0;
      chk_swp_at_q <= 1'b0;
    end else begin
      if (swp_cmd) chk_swp_q <= 1'b1;
      if (launch_w) begin
        chk_wp_q     <= wp_pin;
        chk_swp_at_q <= chk_swp_q;
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !arr_we)); // R1

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy); // R5

  AST_WP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !chk_wp_q); // R7

  AST_LOW_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (arr_we && chk_swp_at_q) |-> arr_addr[ADDR_W-1]); // R8

endmodule

// File: tb/pgwr_commit_tb.sv
`timescale 1ns/1ps
module pgwr_commit_tb_top;
  localparam int WC = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_start = 0, addr_vld = 0, data_vld = 0, bus_stop = 0;
  logic [7:0] addr_byte = 0, data_byte = 0;
  logic       wp_pin = 0, swp_cmd = 0;
  logic       busy, arr_we;
  logic [7:0] arr_addr, arr_wdata;

  always #4 clk = ~clk;

  pgwr_commit #(.DATA_W(8), .ADDR_W(8), .PAGE_W(4), .WC_CYCLES(WC)) dut_i (
    .clk(clk), .rst(rst), .bus_start(bus_start), .addr_vld(addr_vld),
    .addr_byte(addr_byte), .data_vld(data_vld), .data_byte(data_byte),
    .bus_stop(bus_stop), .wp_pin(wp_pin), .swp_cmd(swp_cmd),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int          n_vec = 0, n_bad = 0;
  string       cur_req = "R2";
  logic [15:0] exp_q[$];
  logic [3:0]  m_page, m_ptr;
  logic [7:0]  m_buf [16];
  logic [15:0] m_vld;
  bit          m_swp = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop and compare every array write
  always @(negedge clk) begin
    if (!rst && arr_we) begin
      if (exp_q.size() == 0) chk(0, {cur_req, " unexpected write"}, {arr_addr, arr_wdata}, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_wdata} == e, cur_req, {arr_addr, arr_wdata}, e);
      end
    end
  end

  task automatic send_addr(input logic [7:0] a);
    @(negedge clk) addr_vld = 1; addr_byte = a;
    @(negedge clk) addr_vld = 0;
    m_page = a[7:4]; m_ptr = a[3:0]; m_vld = '0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk) data_vld = 1; data_byte = d;
    @(negedge clk) data_vld = 0;
    m_buf[m_ptr] = d; m_vld[m_ptr] = 1'b1; m_ptr = m_ptr + 1;
  endtask

  task automatic send_start();
    @(negedge clk) bus_start = 1;
    @(negedge clk) bus_start = 0;
    m_vld = '0;
  endtask

  task automatic give_swp();
    @(negedge clk) swp_cmd = 1;
    @(negedge clk) swp_cmd = 0;
    m_swp = 1;
  endtask

  // stop, then check busy window; expected writes queued beforehand
  task automatic finish_txn(input bit go, input bit wp_mid, input bit junk_mid);
    int n;
    if (go) begin
      for (int s = 0; s < 16; s++) begin
        logic [7:0] a;
        a = {m_page, 4'(s)};
        if (m_vld[s] && !wp_pin && !(m_swp && !a[7])) exp_q.push_back({a, m_buf[s]});
      end
    end
    @(negedge clk) bus_stop = 1;
    @(negedge clk) bus_stop = 0;
    if (!go) begin
      for (int k = 0; k < 4; k++) begin
        chk(busy == 1'b0, "R4/R6 no launch", busy, 0);
        @(negedge clk);
      end
    end else begin
      chk(busy == 1'b1, "R5 busy rise", busy, 1);
      n = 0;
      while (busy && n < 1000) begin
        n++;
        if (wp_mid && n == 3) wp_pin = 1;
        bus_start = 0;
        addr_vld  = junk_mid && (n == 5);
        data_vld  = junk_mid && (n == 6);
        bus_stop  = junk_mid && (n == 7);
        addr_byte = 8'h42; data_byte = 8'hEE;
        @(negedge clk);
      end
      addr_vld = 0; data_vld = 0; bus_stop = 0;
      chk(n == WC, "R5 busy length", n, WC);
      if (wp_mid) wp_pin = 0;
    end
    chk(exp_q.size() == 0, {cur_req, " missing writes"}, exp_q.size(), 0);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy == 0 && arr_we == 0, "R1 reset", {busy, arr_we}, 0);

    cur_req = "R2 plain";
    send_addr(8'h35); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    finish_txn(1, 0, 0);

    cur_req = "R2 wrap";
    send_addr(8'h9E);
    for (int i = 0; i < 4; i++) send_byte(8'h10 + 8'(i));
    finish_txn(1, 0, 0);

    cur_req = "R3 overwrite";
    send_addr(8'hC0);
    for (int i = 0; i < 20; i++) send_byte(8'h60 + 8'(i));
    finish_txn(1, 0, 0);

    cur_req = "R4 empty";
    send_addr(8'h20);
    finish_txn(0, 0, 0);
    cur_req = "R4 start discard";
    send_addr(8'h20); send_byte(8'h55); send_byte(8'h56); send_start();
    finish_txn(0, 0, 0);

    cur_req = "R6 busy ignore";
    send_addr(8'h71); send_byte(8'h3C);
    finish_txn(1, 0, 1);
    finish_txn(0, 0, 0);

    cur_req = "R7 wp";
    wp_pin = 1;
    send_addr(8'hD4); send_byte(8'h01); send_byte(8'h02);
    finish_txn(1, 0, 0);
    wp_pin = 0;

    cur_req = "R10 wp mid";
    send_addr(8'h48); send_byte(8'h77); send_byte(8'h78);
    finish_txn(1, 1, 0);

    give_swp();
    cur_req = "R8 low blocked";
    send_addr(8'h10); send_byte(8'h99); send_byte(8'h9A);
    finish_txn(1, 0, 0);
    cur_req = "R8 high open";
    send_addr(8'h80); send_byte(8'hB0); send_byte(8'hB1);
    finish_txn(1, 0, 0);

    give_swp();
    cur_req = "R9 sticky";
    send_addr(8'h7F); send_byte(8'hC7); send_byte(8'hC8);
    finish_txn(1, 0, 0);
    cur_req = "R9 sticky upper";
    send_addr(8'hFF); send_byte(8'hD1); send_byte(8'hD2);
    finish_txn(1, 0, 0);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule